// File: doc/BRIEF.md
# Two-Wire Slave Memory with Auto-Stepping Word Pointer

This block is a slave on a two-wire serial bus. Behind it sits a memory of 256 bytes. The host reaches the memory through a pointer-style protocol:

- The host sends a device byte. Its top four bits are fixed at `1010`. The next three bits must equal the `sel_addr` pins. The last bit selects direction (0 = host writes, 1 = host reads).
- In a write transfer, the first byte after the device byte loads the word pointer. Each later byte is stored at the pointer, and the pointer then steps by one.
- In a read transfer, bytes are returned starting at the current pointer. The pointer steps after each byte. A repeated start followed by a read-direction device byte therefore reads from the location that a preceding write transfer just selected.

Both bus lines are resynchronised to the system clock and filtered before decoding. A level change must persist for `FILT_CYCLES` samples before the decoder sees it. The filtered lines produce four events: clock rise, clock fall, start and stop.

A single control state machine handles the protocol. It has these states:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for a start |
| `ST_ADDR` | Shifts in the device byte |
| `ST_ADDR_ACK` | Acknowledges a matching device byte |
| `ST_PTR` | Shifts in the pointer byte |
| `ST_PTR_ACK` | Acknowledges the pointer byte |
| `ST_WR_BYTE` | Shifts in a data byte |
| `ST_WR_ACK` | Acknowledges a data byte |
| `ST_RD_BYTE` | Shifts a data byte out |
| `ST_RD_ACK` | Samples the host's acknowledge |

It takes these transitions:

- A start moves any state to `ST_ADDR`, and a stop moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_PTR` for a write or to `ST_RD_BYTE` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, then to `ST_WR_BYTE`.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` returns to `ST_RD_BYTE` if the host acknowledged and goes to `ST_IDLE` if it did not.

Each state change happens on a filtered clock fall.

Top module: `i2c_ram_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe` = 0).
- R2: A device byte equal to {`1010`, `sel_addr`[2:0], direction bit} is acknowledged: data is held low through the high phase of the ninth clock.
- R3: A device byte with any other upper seven bits is not acknowledged. The bytes that follow it up to the next start are neither acknowledged nor stored.
- R4: In a write transfer, the first byte loads the word pointer. Each following byte is stored at the pointer, the pointer advances by one, and every such byte is acknowledged.
- R5: A read transfer returns bytes starting at the current pointer and advances the pointer once per byte. The pointer value persists across transfers.
- R6: The pointer wraps from 255 to 0 for both writes and reads.
- R7: When the host does not acknowledge a read byte, the block releases the data line and stops sending until the next start.
- R8: A repeated start in the middle of a byte abandons that byte without storing it, restarts device-byte decoding, and keeps the pointer.
- R9: After a stop, clock pulses without a new start draw no acknowledge, and a stop always leaves the data line released on the next cycle.
- R10: A clock-line pulse shorter than the filter window has no effect on the received bits.
- R11: The block changes `sda_oe` only while the raw clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_addr | input | 3 | Pin-strapped low bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
The hardest case to reach is a repeated start that arrives partway through a data byte while a write transfer is still open. The block must discard the half-received bits, must not store them, and must keep the pointer that was loaded earlier. The bench reaches this case by driving four bits of a byte and then raising data with the clock low. It then issues a start and re-addresses the device for reading. The two bytes read back show that the pointer was kept and that the location was not overwritten. A one-cycle clock glitch placed inside a write byte, followed by a readback, exercises the filter path.

// File: rtl/i2c_ram_pkg.sv
`timescale 1ns/1ps
package i2c_ram_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_bus_frontend.sv
`timescale 1ns/1ps
module i2c_bus_frontend #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_v;
    logic [LINES-1:0] filt_v;
    logic [LINES-1:0] prev_v;

    assign raw_v = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]       sync_q;
        logic [CNT_W-1:0] run_q;
        logic             filt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= 2'b11;
                run_q  <= '0;
                filt_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[0], raw_v[g]};
                if (sync_q[1] != filt_q) begin
                    if (run_q == CNT_W'(FILT_CYCLES - 1)) begin
                        filt_q <= sync_q[1];
                        run_q  <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
        assign filt_v[g] = filt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_v <= '1;
        else        prev_v <= filt_v;
    end

    assign sda_f     = filt_v[1];
    assign scl_rise  = filt_v[0] & ~prev_v[0];
    assign scl_fall  = ~filt_v[0] & prev_v[0];
    assign start_evt = filt_v[0] & prev_v[0] & prev_v[1] & ~filt_v[1];
    assign stop_evt  = filt_v[0] & prev_v[0] & ~prev_v[1] & filt_v[1];
endmodule

// File: rtl/i2c_ram_array.sv
`timescale 1ns/1ps
module i2c_ram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ram_ctrl.sv
`timescale 1ns/1ps
module i2c_ram_ctrl
    import i2c_ram_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_f,
    input  logic [2:0]        sel_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output slv_state_t        state_o
);
    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(BYTE_W);
    localparam logic [BIT_CW-1:0] LAST_TX  = BIT_CW'(BYTE_W - 1);

    slv_state_t        state;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] ptr;
    logic              dir_rd;
    logic              host_ack;
    logic              rx_phase;
    logic              byte_done;

    assign rx_phase  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WR_BYTE);
    assign byte_done = scl_fall && (bit_cnt == FULL_CNT);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            dir_rd   <= 1'b0;
            host_ack <= 1'b0;
        end else if (stop_evt) begin
            state <= ST_IDLE;
        end else if (start_evt) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else begin
            if (rx_phase && scl_rise && bit_cnt != FULL_CNT) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_f};
                bit_cnt <= bit_cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (byte_done) begin
                        if (shreg[BYTE_W-1:1] == {DEV_ID, sel_addr}) begin
                            dir_rd <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (dir_rd) begin
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                            state <= ST_RD_BYTE;
                        end else begin
                            state <= ST_PTR;
                        end
                    end
                end
                ST_PTR: begin
                    if (byte_done) begin
                        ptr   <= shreg[ADDR_W-1:0];
                        state <= ST_PTR_ACK;
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: begin
                    if (byte_done) begin
                        ptr   <= ptr + 1'b1;
                        state <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            state <= ST_RD_ACK;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) host_ack <= ~sda_f;
                    if (scl_fall) begin
                        if (host_ack) begin
                            shreg   <= rd_data;
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RD_BYTE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:                         sda_oe = ~shreg[BYTE_W-1];
            default:                            sda_oe = 1'b0;
        endcase
    end

    assign mem_we    = (state == ST_WR_BYTE) && byte_done && !start_evt && !stop_evt;
    assign mem_addr  = ptr;
    assign mem_wdata = shreg;
    assign state_o   = state;
endmodule

// File: rtl/i2c_ram_slave.sv
`timescale 1ns/1ps
module i2c_ram_slave
    import i2c_ram_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         FILT_CYCLES = 3,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_addr,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    logic              sda_f;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              mem_we;
    logic [ADDR_W-1:0] word_ptr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;
    slv_state_t        ctl_state;

    i2c_bus_frontend #(.FILT_CYCLES(FILT_CYCLES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_ram_ctrl #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_f     (sda_f),
        .sel_addr  (sel_addr),
        .rd_data   (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_addr  (word_ptr),
        .mem_wdata (mem_wdata),
        .state_o   (ctl_state)
    );

    i2c_ram_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (word_ptr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/i2c_ram_checker.sv
`timescale 1ns/1ps
module i2c_ram_checker
    import i2c_ram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] word_ptr,
    input slv_state_t        ctl_state
);
    assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe);

    assert_write_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (word_ptr == $past(word_ptr) + 1'b1));

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && word_ptr == '1) |=> (word_ptr == '0));

    assert_restart_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (ctl_state == ST_ADDR));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_ram_slave i2c_ram_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .mem_we    (mem_we),
    .word_ptr  (word_ptr),
    .ctl_state (ctl_state)
);

// File: tb/i2c_ram_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_ram_slave_tb_top;
    localparam int H = 20;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [2:0] sel_addr = SEL;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] obs_val;
    logic       obs_stb = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_ram_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_addr (sel_addr),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            tick(H/2);
            if (glitch && i == 3) begin
                m_scl = 1'b1; tick(1); m_scl = 1'b0;
            end
            tick(H/2);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        acked = !sda_bus;
        tick(H/2);
        m_scl = 1'b0;
    endtask

    task automatic send_expect(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_byte(b, 1'b0, a);
        check(a == exp_ack, req, a, exp_ack);
    endtask

    // driver: pushes the expected byte, then clocks it out of the design
    task automatic read_expect(input logic [7:0] exp, input bit ack, input string req);
        logic [7:0] b;
        exp_q.push_back(exp);
        req_q.push_back(req);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            m_scl = 1'b1; tick(H/2);
            b[i] = sda_bus;
            tick(H/2);
            m_scl = 1'b0;
        end
        m_sda = ack ? 1'b0 : 1'b1;
        tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0;
        m_sda = 1'b1;
        obs_val = b;
        obs_stb = 1'b1; tick(1); obs_stb = 1'b0;
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(posedge obs_stb);
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", obs_val, 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(obs_val == e, r, obs_val, e);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check(sda_oe == 1'b0 && sda_bus == 1'b1, "R1 reset release", sda_oe, 0);

        // R2/R4: device byte, pointer 0x10, four data bytes
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h10, 1'b1, "R4 ptr ack");
        send_expect(8'h11, 1'b1, "R4 data ack");
        send_expect(8'h22, 1'b1, "R4 data ack");
        send_expect(8'h33, 1'b1, "R4 data ack");
        send_expect(8'h44, 1'b1, "R4 data ack");
        bus_stop();

        // R5: set pointer, repeated start, read three, host NACK on last
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h10, 1'b1, "R4 ptr ack");
        bus_start();
        send_expect(DEV_R, 1'b1, "R2 read device ack");
        read_expect(8'h11, 1'b1, "R5 read first");
        read_expect(8'h22, 1'b1, "R5 read step");
        read_expect(8'h33, 1'b0, "R5 read step");
        tick(H/2);
        check(sda_bus == 1'b1 && sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
        tick(H);
        check(sda_oe == 1'b0, "R7 stays released", sda_oe, 0);
        bus_stop();

        // R5: pointer persists across transfers
        bus_start();
        send_expect(DEV_R, 1'b1, "R2 read device ack");
        read_expect(8'h44, 1'b0, "R5 pointer persists");
        bus_stop();

        // R6: wrap on write and read
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'hFE, 1'b1, "R6 ptr ack");
        send_expect(8'h5A, 1'b1, "R6 data ack");
        send_expect(8'hA5, 1'b1, "R6 data ack");
        send_expect(8'hC3, 1'b1, "R6 data ack wrapped");
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'hFE, 1'b1, "R6 ptr ack");
        bus_start();
        send_expect(DEV_R, 1'b1, "R2 read device ack");
        read_expect(8'h5A, 1'b1, "R6 read FE");
        read_expect(8'hA5, 1'b1, "R6 read FF");
        read_expect(8'hC3, 1'b0, "R6 read 00 after wrap");
        bus_stop();

        // R3: wrong address, following bytes ignored
        bus_start();
        send_expect({4'b1010, 3'b001, 1'b0}, 1'b0, "R3 wrong device nack");
        send_expect(8'h10, 1'b0, "R3 ptr ignored");
        send_expect(8'h99, 1'b0, "R3 data ignored");
        bus_stop();
        bus_start();
        send_expect({4'b1110, SEL, 1'b0}, 1'b0, "R3 wrong id nack");
        bus_stop();
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h10, 1'b1, "R4 ptr ack");
        bus_start();
        send_expect(DEV_R, 1'b1, "R2 read device ack");
        read_expect(8'h11, 1'b0, "R3 memory untouched");
        bus_stop();

        // R9: clocks after stop without start
        send_expect(DEV_W, 1'b0, "R9 no ack without start");
        check(sda_oe == 1'b0, "R9 released", sda_oe, 0);
        bus_stop();

        // R8: repeated start mid-byte
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h20, 1'b1, "R4 ptr ack");
        send_expect(8'h77, 1'b1, "R4 data ack");
        send_expect(8'h88, 1'b1, "R4 data ack");
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h20, 1'b1, "R4 ptr ack");
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
        bus_start();
        send_expect(DEV_R, 1'b1, "R8 decode after restart");
        read_expect(8'h77, 1'b1, "R8 pointer kept, byte not stored");
        read_expect(8'h88, 1'b0, "R8 next location intact");
        bus_stop();

        // R10: short clock glitch inside a byte
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h30, 1'b1, "R4 ptr ack");
        send_byte(8'h3C, 1'b1, a);
        check(a == 1'b1, "R10 ack despite glitch", a, 1);
        send_expect(8'h5D, 1'b1, "R10 data ack after glitch");
        bus_start();
        send_expect(DEV_W, 1'b1, "R2 device ack");
        send_expect(8'h30, 1'b1, "R4 ptr ack");
        bus_start();
        send_expect(DEV_R, 1'b1, "R2 read device ack");
        read_expect(8'h3C, 1'b1, "R10 glitched byte intact");
        read_expect(8'h5D, 1'b0, "R10 next byte intact");
        bus_stop();

        tick(10);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule